// File: doc/BRIEF.md
# Tuner Control Register Slave (two-wire serial bus)

This block is a two-wire serial bus slave that holds the control byte file of a radio tuner. A bus master writes a subaddress and a run of data bytes into a 40-entry register file whose contents drive the analogue sections in parallel. A read returns a single status byte built from seven quality and filter flags. The bus pins are oversampled by the system clock, so the whole slave runs in one clock domain. Clock stretching, 10-bit addressing and general call are not supported.

The device address is seven bits. The upper six bits are a fixed type code, 110001, and the lowest bit is taken from a strap input, so two of these slaves can share one bus. The register file is split into two pages. Entries 0 to 31 form a lower page in which the write pointer wraps. Entries 32 to 39 form an upper page, which is reached by starting a new transfer at subaddress 32 or above.

The protocol engine is a state machine with the following states:
- `ST_IDLE`: waits for a START.
- `ST_ADDR`: receives the address byte.
- `ST_ADDR_ACK`: acknowledges a matching address.
- `ST_SUB`: receives the subaddress.
- `ST_SUB_ACK`: acknowledges the subaddress.
- `ST_WDATA`: receives a data byte.
- `ST_WDATA_ACK`: acknowledges a data byte, commits it and advances the pointer.
- `ST_RDATA`: shifts out the status byte.
- `ST_RD_ACK`: samples the master's acknowledge.
- `ST_IGNORE`: keeps SDA released until the next START or STOP.

The transitions are:
- A STOP from any state goes to `ST_IDLE`.
- A START from any state goes to `ST_ADDR`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` on a mismatch.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read, or to `ST_SUB` for a write.
- `ST_SUB` goes to `ST_SUB_ACK`, and `ST_SUB_ACK` goes to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RDATA` if the master acknowledges, or to `ST_IGNORE` if it does not.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal {110001, addr_strap}, with bit 0 as read (1) or write (0). It pulls SDA low for the whole 9th clock. On any other address it leaves SDA released for the rest of the transfer, and the register file is unchanged.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A STOP returns the slave to idle with SDA released. Bytes clocked without a preceding START are neither acknowledged nor stored.
- R3: In a write, the first byte after the address is taken as the subaddress and is acknowledged.
- R4: Each following data byte is acknowledged and written to the register at the current subaddress when its acknowledge clock ends, after which the subaddress advances by one.
- R5: In the lower page (subaddress 0 to 31), the subaddress advances from 31 back to 0.
- R6: A transfer started at subaddress 32 or above advances linearly. Data bytes aimed at subaddresses above 39 are acknowledged but discarded, and no register changes.
- R7: A read shifts out, MSB first, the status byte with these bits: bit0 flag_adj, bit1 flag_adj_strong, bit2 flag_mute, bit3 flag_dev, bit4 flag_dev_strong, bit5 flag_filt_on, bit6 flag_filt_narrow, bit7 zero. The byte is reloaded for every byte the master acknowledges. After a master non-acknowledge, SDA stays released.
- R8: During and after reset all registers read zero and SDA is released.
- R9: A pulse on SCL or SDA that lasts fewer than three system-clock samples has no effect on the transfer.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Pin-strapped lowest device address bit |
| flag_adj | input | 1 | Adjacent-channel present flag (status bit 0) |
| flag_adj_strong | input | 1 | Strong adjacent-channel flag (status bit 1) |
| flag_mute | input | 1 | Weak-signal mute flag (status bit 2) |
| flag_dev | input | 1 | Deviation flag (status bit 3) |
| flag_dev_strong | input | 1 | Over-deviation flag (status bit 4) |
| flag_filt_on | input | 1 | Narrow IF filter engaged (status bit 5) |
| flag_filt_narrow | input | 1 | Narrowest filter bandwidth selected (status bit 6) |
| ctrl_regs | output | REG_COUNT*8 | Register file, entry k at bits [8k+7:8k] |
| sda_pull | output | 1 | Open-drain SDA pull-down enable |

## Verification
The bench uses the default parameters: 40 registers, a 32-entry lower page, two synchroniser stages and a three-sample filter. This places the lower-page wrap at 31, the last real register at 39, and discarded subaddresses all within a few short transfers. A bus half-period of 16 system clocks leaves ample margin over the five-sample input latency. This still allows two-sample glitches to be injected on either line in the middle of a byte, to show that the filter rejects them.

// File: rtl/tcs_i2c_pkg.sv
package tcs_i2c_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

endpackage

// File: rtl/tcs_pin_filter.sv
// Synchroniser followed by a majority-free agreement filter: the output
// follows the input only after FILT_LEN consecutive equal samples.
module tcs_pin_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FILT_LEN-1:0]    hist_q;
    logic                   out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
            if (&hist_q) begin
                out_q <= 1'b1;
            end else if (~|hist_q) begin
                out_q <= 1'b0;
            end
        end
    end

    assign pin_out = out_q;

endmodule

// File: rtl/tcs_bus_events.sv
// Turns the filtered lines into edge and START/STOP strobes.
module tcs_bus_events
    import tcs_i2c_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.scl_rise = scl_f & ~scl_p;
        ev.scl_fall = ~scl_f & scl_p;
        ev.start    = scl_f & scl_p & sda_p & ~sda_f;
        ev.stop     = scl_f & scl_p & ~sda_p & sda_f;
    end

endmodule

// File: rtl/tcs_reg_file.sv
// Control register file with a single write port and a flat read-out.
module tcs_reg_file #(
    parameter int REG_COUNT = 40,
    localparam int AW = $clog2(REG_COUNT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [7:0]            wr_data,
    output logic [REG_COUNT*8-1:0] regs_flat
);

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
        logic [7:0] entry_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q <= '0;
            end else if (wr_en && (wr_addr == AW'(g))) begin
                entry_q <= wr_data;
            end
        end

        assign regs_flat[g*8 +: 8] = entry_q;
    end

endmodule

// File: rtl/tcs_proto_fsm.sv
// Byte-level protocol engine: address match, subaddress, paged pointer,
// write commit and status read-out.
module tcs_proto_fsm
    import tcs_i2c_pkg::*;
#(
    parameter logic [5:0] TYPE_CODE = 6'b110001,
    parameter int REG_COUNT = 40,
    parameter int PAGE_SIZE = 32,
    localparam int AW = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_ev_t           ev,
    input  logic              addr_strap,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_pull
);

    localparam logic [BYTE_W-1:0] PAGE_LAST = BYTE_W'(PAGE_SIZE - 1);
    localparam logic [BYTE_W-1:0] PAGE_END  = BYTE_W'(PAGE_SIZE);
    localparam logic [BYTE_W-1:0] REG_LIM   = BYTE_W'(REG_COUNT);

    bus_state_e        state_q;
    bus_state_e        state_d;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shift_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              rw_q;
    logic              nack_q;

    logic rx_done;
    logic tx_done;
    logic addr_hit;

    assign rx_done  = ev.scl_fall && (bit_cnt == 4'd8);
    assign tx_done  = ev.scl_fall && (bit_cnt == 4'd7);
    assign addr_hit = (shift_q[7:1] == {TYPE_CODE, addr_strap});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ev.stop) begin
            state_d = ST_IDLE;
        end else if (ev.start) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (rx_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (ev.scl_fall) state_d = rw_q ? ST_RDATA : ST_SUB;
                ST_SUB:       if (rx_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:   if (ev.scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (rx_done) state_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (ev.scl_fall) state_d = ST_WDATA;
                ST_RDATA:     if (tx_done) state_d = ST_RD_ACK;
                ST_RD_ACK:    if (ev.scl_fall) state_d = nack_q ? ST_IGNORE : ST_RDATA;
                ST_IGNORE:    state_d = ST_IGNORE;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shift_q <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
        end else if (ev.start || ev.stop) begin
            bit_cnt <= '0;
        end else begin
            case (state_q)
                ST_ADDR, ST_SUB, ST_WDATA: begin
                    if (ev.scl_rise) begin
                        shift_q <= {shift_q[BYTE_W-2:0], ev.sda};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (rx_done && state_q == ST_ADDR) begin
                        rw_q <= shift_q[0];
                    end
                    if (rx_done && state_q == ST_SUB) begin
                        ptr_q <= shift_q;
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        tx_q    <= status_byte;
                    end
                end
                ST_SUB_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                    end
                end
                ST_WDATA_ACK: begin
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        if (ptr_q < PAGE_END) begin
                            ptr_q <= (ptr_q == PAGE_LAST) ? '0 : ptr_q + 1'b1;
                        end else if (ptr_q != '1) begin
                            ptr_q <= ptr_q + 1'b1;
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        tx_q    <= {tx_q[BYTE_W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        nack_q <= ev.sda;
                    end
                    if (ev.scl_fall) begin
                        bit_cnt <= '0;
                        tx_q    <= status_byte;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_pull = 1'b0;
        wr_en    = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_SUB_ACK: sda_pull = 1'b1;
            ST_WDATA_ACK: begin
                sda_pull = 1'b1;
                wr_en    = ev.scl_fall && (ptr_q < REG_LIM);
            end
            ST_RDATA: sda_pull = ~tx_q[BYTE_W-1];
            default:  sda_pull = 1'b0;
        endcase
    end

    assign wr_addr = ptr_q[AW-1:0];
    assign wr_data = shift_q;

endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c
    import tcs_i2c_pkg::*;
#(
    parameter logic [5:0] TYPE_CODE   = 6'b110001,
    parameter int         REG_COUNT   = 40,
    parameter int         PAGE_SIZE   = 32,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    input  logic                   addr_strap,
    input  logic                   flag_adj,
    input  logic                   flag_adj_strong,
    input  logic                   flag_mute,
    input  logic                   flag_dev,
    input  logic                   flag_dev_strong,
    input  logic                   flag_filt_on,
    input  logic                   flag_filt_narrow,
    output logic [REG_COUNT*8-1:0] ctrl_regs,
    output logic                   sda_pull
);

    localparam int AW = $clog2(REG_COUNT);

    logic [1:0]        pin_raw;
    logic [1:0]        pin_filt;
    bus_ev_t           ev;
    logic              scl_filt;
    logic              start_det;
    logic              stop_det;
    logic              wr_en;
    logic [AW-1:0]     wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] status_byte;

    assign pin_raw = {scl_in, sda_in};

    for (genvar p = 0; p < 2; p++) begin : g_pin
        tcs_pin_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_in (pin_raw[p]),
            .pin_out(pin_filt[p])
        );
    end

    tcs_bus_events u_ev (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_f(pin_filt[1]),
        .sda_f(pin_filt[0]),
        .ev   (ev)
    );

    assign scl_filt  = ev.scl;
    assign start_det = ev.start;
    assign stop_det  = ev.stop;

    assign status_byte = {1'b0, flag_filt_narrow, flag_filt_on, flag_dev_strong,
                          flag_dev, flag_mute, flag_adj_strong, flag_adj};

    tcs_proto_fsm #(
        .TYPE_CODE(TYPE_CODE),
        .REG_COUNT(REG_COUNT),
        .PAGE_SIZE(PAGE_SIZE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .addr_strap (addr_strap),
        .status_byte(status_byte),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .sda_pull   (sda_pull)
    );

    tcs_reg_file #(
        .REG_COUNT(REG_COUNT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .regs_flat(ctrl_regs)
    );

endmodule

// File: rtl/tcs_i2c_chk.sv
module tcs_i2c_chk #(
    parameter int REG_COUNT = 40,
    localparam int AW = $clog2(REG_COUNT)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_f,
    input logic                   start_det,
    input logic                   stop_det,
    input logic                   sda_pull,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [REG_COUNT*8-1:0] ctrl_regs
);

    p_drive_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_pull));

    p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_pull);

    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_pull);

    p_regs_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(ctrl_regs));

    p_commit_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_f);

    p_write_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < REG_COUNT));

endmodule

bind tuner_ctl_i2c tcs_i2c_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_filt),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_pull (sda_pull),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .ctrl_regs(ctrl_regs)
);

// File: tb/tuner_ctl_i2c_test.sv
`timescale 1ns/1ps
module tuner_ctl_i2c_test;

    localparam int NREG = 40;
    localparam int H    = 16;

    // {subaddress, data0, data1, landing index of data0, of data1}; FF = discarded
    localparam logic [39:0] WR_VEC [0:6] = '{
        40'h00_11_22_00_01,
        40'h05_A5_5A_05_06,
        40'h1F_3C_C3_1F_00,
        40'h20_77_88_20_21,
        40'h27_99_66_27_FF,
        40'h2D_12_34_FF_FF,
        40'h14_F0_0F_14_15
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic strap = 1'b0;
    logic [6:0] flags = '0;
    logic [NREG*8-1:0] ctrl_regs;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int total = 0;
    int bad = 0;
    int r10_viol = 0;
    bit done = 0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    tuner_ctl_i2c uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .addr_strap(strap),
        .flag_adj(flags[0]), .flag_adj_strong(flags[1]), .flag_mute(flags[2]),
        .flag_dev(flags[3]), .flag_dev_strong(flags[4]), .flag_filt_on(flags[5]),
        .flag_filt_narrow(flags[6]),
        .ctrl_regs(ctrl_regs), .sda_pull(sda_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic high_phase(input bit dip, output logic line_s, output logic pull_s);
        logic p0;
        scl = 1'b1;
        tick(4);
        p0 = sda_pull;
        tick(H/2 - 4);
        line_s = sda_line;
        pull_s = sda_pull;
        if (dip) begin
            sda_m = 1'b0;
            tick(2);
            sda_m = 1'b1;
        end
        tick(H/2);
        if (sda_pull !== p0) r10_viol++;
        scl = 1'b0;
        tick(2);
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        tick(H/2);
        scl = 1'b1;
        tick(H);
        sda_m = 1'b0;
        tick(H);
        scl = 1'b0;
        tick(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        tick(H);
        scl = 1'b1;
        tick(H);
        sda_m = 1'b1;
        tick(H);
    endtask

    // gmode 1: short SCL pulse in the first low phase; gmode 2: short SDA dip in the first high phase
    task automatic send_byte(input logic [7:0] b, input int gmode, output bit ack);
        logic ls, ps;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (i == 7 && gmode == 1) begin
                tick(H/2);
                scl = 1'b1;
                tick(2);
                scl = 1'b0;
                tick(H/2 - 2);
            end else begin
                tick(H);
            end
            high_phase(i == 7 && gmode == 2, ls, ps);
        end
        sda_m = 1'b1;
        tick(H);
        high_phase(1'b0, ls, ps);
        ack = ps;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] val);
        logic ls, ps;
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1;
            tick(H);
            high_phase(1'b0, ls, ps);
            val[i] = ls;
        end
        sda_m = ~mack;
        tick(H);
        high_phase(1'b0, ls, ps);
    endtask

    task automatic cmp_regs(input string req, input string what);
        int bi;
        bi = -1;
        for (int k = 0; k < NREG; k++) begin
            if (ctrl_regs[k*8 +: 8] !== model[k] && bi < 0) bi = k;
        end
        if (bi < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, $sformatf("%s reg%0d", what, bi), ctrl_regs[bi*8 +: 8], model[bi]);
    endtask

    task automatic write_tx(input logic [7:0] dev, input logic [7:0] sub,
                            input logic [7:0] d0, input logic [7:0] d1, input int nd,
                            input int gmode, output logic [3:0] acks);
        bit a;
        acks = '0;
        bus_start();
        send_byte(dev, 0, a);  acks[3] = a;
        send_byte(sub, 0, a);  acks[2] = a;
        send_byte(d0, gmode, a); acks[1] = a;
        if (nd > 1) begin
            send_byte(d1, 0, a); acks[0] = a;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [3:0]  acks;
        logic [7:0]  rv;
        logic [39:0] e;
        bit          a;

        for (int k = 0; k < NREG; k++) model[k] = 8'h00;
        tick(10);
        chk(ctrl_regs == '0, "R8", "regs in reset", ctrl_regs[63:0], 0);
        rst_n = 1'b1;
        tick(10);
        chk(ctrl_regs == '0, "R8", "regs after reset", ctrl_regs[63:0], 0);
        chk(sda_pull == 1'b0, "R8", "sda released after reset", sda_pull, 0);

        // R2: bytes clocked with no START are ignored
        scl = 1'b0;
        tick(H);
        send_byte(8'hC4, 0, a);
        chk(a == 1'b0, "R2", "address ack without START", a, 0);
        send_byte(8'h02, 0, a);
        send_byte(8'hAB, 0, a);
        chk(a == 1'b0, "R2", "data ack without START", a, 0);
        bus_stop();
        cmp_regs("R2", "no write without START");

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < 7; v++) begin
            e = WR_VEC[v];
            write_tx(8'hC4, e[39:32], e[31:24], e[23:16], 2, 0, acks);
            chk(acks == 4'hF, "R3", $sformatf("acks vec%0d", v), acks, 4'hF);
            if (e[15:8] != 8'hFF) model[e[15:8]] = e[31:24];
            if (e[7:0]  != 8'hFF) model[e[7:0]]  = e[23:16];
            cmp_regs(v == 2 ? "R5" : ((v == 4 || v == 5) ? "R6" : "R4"),
                     $sformatf("regs vec%0d", v));
        end

        // R1: wrong address with strap low
        write_tx(8'hC6, 8'h0A, 8'hEE, 8'h00, 1, 0, acks);
        chk(acks == 4'h0, "R1", "mismatched address acks", acks, 0);
        cmp_regs("R1", "mismatched address no write");

        // R1: strap high selects the other address
        strap = 1'b1;
        write_tx(8'hC6, 8'h0A, 8'h5C, 8'h00, 1, 0, acks);
        chk(acks == 4'hE, "R1", "strapped address acks", acks, 4'hE);
        model[10] = 8'h5C;
        cmp_regs("R1", "strapped address write");

        // R9: short SCL pulse, then short SDA dip
        write_tx(8'hC6, 8'h03, 8'h96, 8'h00, 1, 1, acks);
        chk(acks == 4'hE, "R9", "acks with SCL glitch", acks, 4'hE);
        model[3] = 8'h96;
        cmp_regs("R9", "data with SCL glitch");
        write_tx(8'hC6, 8'h04, 8'hE1, 8'h00, 1, 2, acks);
        chk(acks == 4'hE, "R9", "acks with SDA dip", acks, 4'hE);
        model[4] = 8'hE1;
        cmp_regs("R9", "data with SDA dip");

        // R7: status read
        flags = 7'b1010011;
        bus_start();
        send_byte(8'hC7, 0, a);
        chk(a == 1'b1, "R7", "read address ack", a, 1);
        read_byte(1'b1, rv);
        chk(rv == 8'h53, "R7", "first status byte", rv, 8'h53);
        read_byte(1'b0, rv);
        chk(rv == 8'h53, "R7", "second status byte", rv, 8'h53);
        read_byte(1'b0, rv);
        chk(rv == 8'hFF, "R7", "bus released after nack", rv, 8'hFF);
        bus_stop();
        flags = 7'h7F;
        bus_start();
        send_byte(8'hC7, 0, a);
        read_byte(1'b0, rv);
        chk(rv == 8'h7F, "R7", "all flags set, top bit zero", rv, 8'h7F);
        bus_stop();
        chk(sda_pull == 1'b0, "R2", "released after STOP", sda_pull, 0);
        cmp_regs("R7", "reads leave registers");

        chk(r10_viol == 0, "R10", "SDA drive changes with SCL high", r10_viol, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule